// File: doc/BRIEF.md
# Multiplexed Three-Digit Decimal Display Driver

This block shows an 8-bit unsigned value as three decimal digits on a seven-segment display whose segment lines are shared by all digits. A producer offers a value together with a one-cycle valid strobe. The block splits the value into hundreds, tens and units and keeps those three digits in registers. A prescaler divides the system clock down to a refresh tick. On every tick, one digit's segment pattern is driven together with its digit-select line.

The digit-select port is 8 bits wide, and only its upper three bits are ever driven. Bit 5 enables the units digit, bit 6 the tens digit and bit 7 the hundreds digit. The scan visits them in that order and then starts again at bit 5. The tick period is set by two parameters: the clock frequency and the refresh rate. The default refresh rate gives a 2 ms tick.

Top module: `dec3_scan_display`

## Requirements
- R1: While `rst` is high at a rising edge, `sel` and `seg` are driven to all zeros on that edge.
- R2: `sel` and `seg` change only on refresh ticks. The first tick after reset is the DIV-th rising edge with `rst` low, and ticks then repeat every DIV edges. DIV = CLK_HZ / SCAN_HZ, and DIV must be at least 2.
- R3: Successive ticks drive `sel` through 8'h20, 8'h40, 8'h80 and then back to 8'h20, repeating. The first tick after reset drives 8'h20.
- R4: `sel` is either zero or has exactly one bit set among bits 7..5. Bits 4..0 are always zero.
- R5: `seg` carries the pattern of the digit chosen by `sel`. Bit 5 of `sel` chooses units, bit 6 tens and bit 7 hundreds. The patterns, written as seg[6:0], are: 0→1111110, 1→0001100, 2→0110111, 3→0011111, 4→1001101, 5→1011011, 6→1111011, 7→0001110, 8→1111111, 9→1011111.
- R6: A strobed value v is split into hundreds = v/100, tens = (v/10) mod 10 and units = v mod 10. For example, 255 gives 2, 5, 5.
- R7: From reset until the first strobe, the digits shown are hundreds 1, tens 2 and units 3.
- R8: The three digit registers are loaded together on the rising edge where `sample_vld` is high. A tick on that same edge still shows the old digit. The new digits appear from the next tick onward.
- R9: A change on `sample` while `sample_vld` is low has no effect on what is displayed.
- R10: A reset in the middle of a run restores the prescaler, the scan position and the digits 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_vld | input | 1 | One-cycle strobe; loads `sample` |
| sample | input | 8 | Unsigned value to display |
| seg | output | 7 | Segment pattern, registered |
| sel | output | 8 | One-hot digit select, bits 7..5 used, registered |

## Verification
The bench loads the digit boundaries 0, 9, 10, 99, 100 and 255 and reads all three digits back off the multiplexed bus. A wrong divide or modulo step would show up as a bad tens digit at 99 or 100, or a bad hundreds digit at 255. It follows the select rotation past its wrap, so a shift register that runs out to zero or lands on bit 4 is caught. Random strobes, some of them on a tick edge, are compared every cycle against a bench model. This exposes a design that shows a new digit on the very tick it was loaded, or that latches `sample` without the strobe. A mid-run reset checks that the power-up digits 1, 2 and 3 and a blank output come back.

// File: rtl/dec3_scan_display.sv
module dec3_scan_display #(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned SCAN_HZ = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sample_vld,
  input  logic [7:0] sample,
  output logic [6:0] seg,
  output logic [7:0] sel
);
  localparam int unsigned DIV = CLK_HZ / SCAN_HZ;
  localparam int unsigned CW  = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [7:0]  SCAN_START = 8'h20;

  logic [CW-1:0] div_q;
  logic [7:0]    scan_q;
  logic [3:0]    hun_q, ten_q, one_q;
  logic [3:0]    cur;

  logic       tick;
  logic [7:0] scan_shl;
  logic [3:0] hun_d, ten_d, one_d;

  assign tick     = (div_q == CW'(DIV - 1));
  assign scan_shl = {scan_q[6:0], 1'b0};
  assign hun_d    = 4'(sample / 8'd100);
  assign ten_d    = 4'((sample / 8'd10) % 8'd10);
  assign one_d    = 4'(sample % 8'd10);

  function automatic logic [6:0] seg_code(input logic [3:0] d);
    case (d)
      4'd0:    seg_code = 7'b1111110;
      4'd1:    seg_code = 7'b0001100;
      4'd2:    seg_code = 7'b0110111;
      4'd3:    seg_code = 7'b0011111;
      4'd4:    seg_code = 7'b1001101;
      4'd5:    seg_code = 7'b1011011;
      4'd6:    seg_code = 7'b1111011;
      4'd7:    seg_code = 7'b0001110;
      4'd8:    seg_code = 7'b1111111;
      4'd9:    seg_code = 7'b1011111;
      default: seg_code = 7'b0000000;
    endcase
  endfunction

  always_comb begin
    case (scan_q)
      8'h80:   cur = hun_q;
      8'h40:   cur = ten_q;
      default: cur = one_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      scan_q <= SCAN_START;
      sel    <= '0;
      seg    <= '0;
    end else if (tick) begin
      div_q  <= '0;
      sel    <= scan_q;
      seg    <= seg_code(cur);
      scan_q <= (scan_shl == 8'h00) ? SCAN_START : scan_shl;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hun_q <= 4'd1;
      ten_q <= 4'd2;
      one_q <= 4'd3;
    end else if (sample_vld) begin
      hun_q <= hun_d;
      ten_q <= ten_d;
      one_q <= one_d;
    end
  end
endmodule

// File: rtl/dec3_scan_display_chk.sv
module dec3_scan_display_chk (
  input logic       clk,
  input logic       rst,
  input logic [6:0] seg,
  input logic [7:0] sel
);
  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel) && (sel[4:0] == 5'b0));

  // R3
  sel_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sel) && $past(sel) == 8'h20) |-> sel == 8'h40);

  // R3
  sel_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sel) && $past(sel) == 8'h80) |-> sel == 8'h20);

  // R2
  seg_with_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(seg) |-> !$stable(sel));

  // R1
  blank_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel == 8'h00 && seg == 7'h00));
endmodule

bind dec3_scan_display dec3_scan_display_chk u_chk (
  .clk(clk), .rst(rst), .seg(seg), .sel(sel)
);

// File: tb/dec3_scan_display_test.sv
module dec3_scan_display_test;
  localparam int P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sample_vld = 1'b0;
  logic [7:0] sample = 8'd0;
  logic [6:0] seg;
  logic [7:0] sel;

  int n_chk = 0, n_bad = 0;
  bit run_cmp = 1'b0;
  bit done = 1'b0;
  int cyc = 0;

  always #10 clk = ~clk;

  dec3_scan_display #(.CLK_HZ(5000), .SCAN_HZ(500)) uut (
    .clk(clk), .rst(rst), .sample_vld(sample_vld), .sample(sample),
    .seg(seg), .sel(sel)
  );

  function automatic logic [6:0] enc(input int d);
    case (d)
      0: return 7'b1111110;  1: return 7'b0001100;
      2: return 7'b0110111;  3: return 7'b0011111;
      4: return 7'b1001101;  5: return 7'b1011011;
      6: return 7'b1111011;  7: return 7'b0001110;
      8: return 7'b1111111;  9: return 7'b1011111;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic int dig(input int v, input int pos);
    if (pos == 2) return v / 100;
    if (pos == 1) return (v / 10) % 10;
    return v % 10;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference model: index 0=units,1=tens,2=hundreds
  int m_cnt, m_idx;
  int m_dig [3];
  logic [7:0] exp_sel;
  logic [6:0] exp_seg;
  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= 0; m_idx <= 0;
      m_dig[0] <= 3; m_dig[1] <= 2; m_dig[2] <= 1;
      exp_sel <= 8'h00; exp_seg <= 7'h00;
    end else begin
      if (m_cnt == P - 1) begin
        m_cnt   <= 0;
        exp_sel <= 8'h20 << m_idx;
        exp_seg <= enc(m_dig[m_idx]);
        m_idx   <= (m_idx == 2) ? 0 : m_idx + 1;
      end else m_cnt <= m_cnt + 1;
      if (sample_vld) begin
        m_dig[0] <= dig(int'(sample), 0);
        m_dig[1] <= dig(int'(sample), 1);
        m_dig[2] <= dig(int'(sample), 2);
      end
    end
  end

  always @(negedge clk) if (run_cmp && !done) begin
    check(sel == exp_sel, "R2,R3", int'(sel), int'(exp_sel));
    check(seg == exp_seg, "R5,R8", int'(seg), int'(exp_seg));
    check(sel[4:0] == 5'b0 && $countones(sel) <= 1, "R4", int'(sel), int'(exp_sel));
  end

  // capture the three displayed patterns over one full scan
  task automatic capture(output logic [6:0] h, output logic [6:0] t, output logic [6:0] u);
    h = 'x; t = 'x; u = 'x;
    for (int i = 0; i < 3 * P + 1; i++) begin
      @(negedge clk);
      case (sel)
        8'h80: h = seg;
        8'h40: t = seg;
        8'h20: u = seg;
        default: ;
      endcase
    end
  endtask

  task automatic expect_shown(input int v, input string req);
    logic [6:0] h, t, u;
    capture(h, t, u);
    check(h === enc(dig(v, 2)), req, int'(h), int'(enc(dig(v, 2))));
    check(t === enc(dig(v, 1)), req, int'(t), int'(enc(dig(v, 1))));
    check(u === enc(dig(v, 0)), req, int'(u), int'(enc(dig(v, 0))));
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk); sample = v; sample_vld = 1'b1;
    @(negedge clk); sample_vld = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    int vals [6] = '{0, 9, 10, 99, 100, 255};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state blank
    check(sel == 8'h00, "R1", int'(sel), 0);
    check(seg == 7'h00, "R1", int'(seg), 0);
    rst = 1'b0;
    run_cmp = 1'b1;
    // R3: first tick lands on units
    repeat (P) @(negedge clk);
    check(sel == 8'h20, "R3", int'(sel), 8'h20);
    // R7: power-up digits 1,2,3
    expect_shown(123, "R7");
    // R6: boundary splits
    foreach (vals[k]) begin
      load(8'(vals[k]));
      repeat (3 * P) @(negedge clk);
      expect_shown(vals[k], "R6");
    end
    // R9: sample change without strobe is ignored
    @(negedge clk); sample = 8'd77;
    repeat (4 * P) @(negedge clk);
    expect_shown(255, "R9");
    // R8: random strobes at random times, some on tick edges, vs model
    for (int i = 0; i < 40; i++) begin
      repeat ($urandom_range(0, 2 * P)) @(negedge clk);
      load(8'($urandom_range(0, 255)));
    end
    repeat (4 * P) @(negedge clk);
    // R10: mid-run reset
    load(8'd58);
    repeat (P + 3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(sel == 8'h00 && seg == 7'h00, "R10", int'({sel, 1'b0, seg}), 0);
    rst = 1'b0;
    repeat (P) @(negedge clk);
    check(sel == 8'h20, "R10", int'(sel), 8'h20);
    expect_shown(123, "R10");
    finish_run();
  end
endmodule